// File: doc/BRIEF.md
# Offset Trim Calibration Sequencer

This block finds the offset trim code of one converter channel by itself, with no software stepping involved. A one-cycle start request begins a run. During the run the block turns the channel's normal output off and feeds the converter a fixed mid-scale data word. It saves the channel's mode setting and replaces it with a calibration mode. It then tries 5-bit trim candidates. Each candidate is held for a fixed settle time, and then the block reads a comparator flag from the analog side.

The search uses successive halving. The first candidate is mid-range and the first step is half of that. After each comparison the step halves. A high flag moves the candidate down by the step and a low flag moves it up. When the last step of one is done, the block holds the result for one more settle period. The answer it wants is the first code at which the flag goes high. So if the flag is still low at that point, the code is raised by one, and it stops at the top code instead of wrapping. When the run ends, the block restores the saved mode, marks the trim as user-sourced and pulses done.

While idle, the block also accepts a direct write of a trim code and a write of the channel mode. The applied trim code can be read on its output at all times.

Top module: `trim_cal_seq`

## Requirements
- R1: After reset the trim code equals the FACT_TRIM parameter, trim_user is 0 (factory source), chan_mode equals MODE_RST, and busy, cal_en, done and err are 0.
- R2: A cal_start sampled while idle makes busy and cal_en high on the next cycle, sets the trim code to mid-range (16 for a 5-bit code) and sets chan_mode to CAL_MODE.
- R3: While busy, out_en is 0 and dat_out is mid-scale (0x800 for 12 bits, that is 1 << (DW-1)). While idle, out_en follows out_en_cfg and dat_out follows dat_in.
- R4: Each candidate is held for SETTLE_CYC cycles, and then cmp_flag is sampled. If the flag is high the step is subtracted from the candidate; if it is low the step is added. The steps are 8, 4, 2 and 1, in that order.
- R5: After the step of 1, the result is held for SETTLE_CYC more cycles. If cmp_flag is then low, the code becomes the result plus one, saturating at 31. If cmp_flag is high, the code is kept.
- R6: Exactly 5*SETTLE_CYC cycles after the start edge, busy and cal_en fall, done is high for exactly one cycle, and trim_user becomes 1.
- R7: The chan_mode value applied at start is restored when the run finishes. A mode_wr while busy is ignored. A mode_wr while idle (without cal_start) loads mode_wdata on the next cycle.
- R8: A cal_start sampled while busy gives a one-cycle err pulse on the next cycle and does not disturb the run in progress.
- R9: A usr_wr while idle (without cal_start) loads usr_code into the trim code on the next cycle and sets trim_user to 1. A usr_wr while busy, or in the same cycle as cal_start, is ignored.
- R10: While idle and with no usr_wr, the trim code holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start | input | 1 | One-cycle request to begin a calibration run |
| cmp_flag | input | 1 | Comparator flag from the analog side |
| usr_wr | input | 1 | Direct trim code write strobe |
| usr_code | input | TW | Trim code for a direct write |
| mode_wr | input | 1 | Channel mode write strobe |
| mode_wdata | input | MW | Channel mode value to write |
| out_en_cfg | input | 1 | Configured channel output enable |
| dat_in | input | DW | Normal channel data word |
| out_en | output | 1 | Channel output enable applied to the converter |
| dat_out | output | DW | Data word applied to the converter |
| chan_mode | output | MW | Channel mode applied to the converter |
| cal_en | output | 1 | Calibration enable to the analog side |
| trim_code | output | TW | Applied trim code (readback) |
| trim_user | output | 1 | Trim source: 0 factory, 1 user |
| busy | output | 1 | Calibration run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| err | output | 1 | One-cycle pulse for a start request rejected while busy |

## Verification
The assertions check the following on every cycle:
- each run opens at mid-range;
- done coincides with the fall of busy and lasts one cycle;
- a rejected start always follows a busy cycle;
- the applied mode and the trim code stay frozen where no write or step may touch them.

The search result itself depends on the comparator's threshold, so only the bench's scenarios can show it. These scenarios include the two extremes where the flag is always high or never high, and the saturating final step. The same holds for the restored mode value and for writes dropped during a run.

// File: rtl/trim_cal_seq.sv
module trim_cal_seq #(
  parameter int TW         = 5,
  parameter int DW         = 12,
  parameter int MW         = 3,
  parameter int SETTLE_CYC = 50,
  parameter logic [TW-1:0] FACT_TRIM = 10,
  parameter logic [MW-1:0] MODE_RST  = 1,
  parameter logic [MW-1:0] CAL_MODE  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cal_start,
  input  logic          cmp_flag,
  input  logic          usr_wr,
  input  logic [TW-1:0] usr_code,
  input  logic          mode_wr,
  input  logic [MW-1:0] mode_wdata,
  input  logic          out_en_cfg,
  input  logic [DW-1:0] dat_in,
  output logic          out_en,
  output logic [DW-1:0] dat_out,
  output logic [MW-1:0] chan_mode,
  output logic          cal_en,
  output logic [TW-1:0] trim_code,
  output logic          trim_user,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [TW-1:0] MID_TRIM = TW'(1) << (TW - 1);
  localparam logic [TW-1:0] STEP0    = TW'(1) << (TW - 2);
  localparam logic [DW-1:0] MID_DATA = DW'(1) << (DW - 1);

  typedef enum logic [1:0] {S_IDLE, S_SRCH, S_CHK} st_t;

  st_t           st_q;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] trim_q, step_q;
  logic [MW-1:0] mode_q, save_q;
  logic          user_q, done_q, err_q;

  wire          run  = (st_q != S_IDLE);
  wire          tick = (cnt_q == CW'(SETTLE_CYC - 1));
  wire [TW:0]   inc  = {1'b0, trim_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      trim_q <= FACT_TRIM;
      step_q <= '0;
      mode_q <= MODE_RST;
      save_q <= '0;
      user_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= cal_start && run;
      case (st_q)
        S_IDLE: begin
          if (cal_start) begin
            st_q   <= S_SRCH;
            cnt_q  <= '0;
            trim_q <= MID_TRIM;
            step_q <= STEP0;
            save_q <= mode_q;
            mode_q <= CAL_MODE;
          end else begin
            if (usr_wr) begin
              trim_q <= usr_code;
              user_q <= 1'b1;
            end
            if (mode_wr) mode_q <= mode_wdata;
          end
        end
        S_SRCH: begin
          if (tick) begin
            cnt_q  <= '0;
            trim_q <= cmp_flag ? trim_q - step_q : trim_q + step_q;
            step_q <= step_q >> 1;
            if (step_q == TW'(1)) st_q <= S_CHK;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_CHK: begin
          if (tick) begin
            if (!cmp_flag) trim_q <= inc[TW] ? '1 : inc[TW-1:0];
            cnt_q  <= '0;
            st_q   <= S_IDLE;
            mode_q <= save_q;
            user_q <= 1'b1;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = run;
  assign cal_en    = run;
  assign out_en    = out_en_cfg && !run;
  assign dat_out   = run ? MID_DATA : dat_in;
  assign chan_mode = mode_q;
  assign trim_code = trim_q;
  assign trim_user = user_q;
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/trim_cal_seq_chk.sv
module trim_cal_seq_chk #(
  parameter int TW = 5,
  parameter int MW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cal_start,
  input logic          usr_wr,
  input logic          mode_wr,
  input logic [MW-1:0] chan_mode,
  input logic [TW-1:0] trim_code,
  input logic          trim_user,
  input logic          busy,
  input logic          done,
  input logic          err
);
  localparam logic [TW-1:0] MID_TRIM = TW'(1) << (TW - 1);

  // R2
  start_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> trim_code == MID_TRIM);

  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done && trim_user);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  err_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(busy) && $past(cal_start));

  // R7
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(chan_mode));

  // R7
  mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$past(mode_wr)) |-> $stable(chan_mode));

  // R10
  trim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$past(usr_wr)) |-> $stable(trim_code));
endmodule

bind trim_cal_seq trim_cal_seq_chk #(.TW(TW), .MW(MW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .usr_wr(usr_wr),
  .mode_wr(mode_wr), .chan_mode(chan_mode), .trim_code(trim_code),
  .trim_user(trim_user), .busy(busy), .done(done), .err(err)
);

// File: tb/trim_cal_seq_tb.sv
module trim_cal_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int S    = 5;
  localparam int TW   = 5;
  localparam int DW   = 12;
  localparam int MW   = 3;
  localparam int FACT = 10;
  localparam int MRST = 1;
  localparam int CALM = 0;

  logic clk = 0;
  logic rst_n = 0;
  logic cal_start = 0, usr_wr = 0, mode_wr = 0, out_en_cfg = 1;
  logic [TW-1:0] usr_code = 0;
  logic [MW-1:0] mode_wdata = 0;
  logic [DW-1:0] dat_in = 12'h123;
  logic cmp_flag;
  logic out_en, cal_en, trim_user, busy, done, err;
  logic [DW-1:0] dat_out;
  logic [MW-1:0] chan_mode;
  logic [TW-1:0] trim_code;

  int tgt = 0;
  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // comparator model: flag is high from code tgt upward
  assign cmp_flag = (int'(trim_code) >= tgt);

  trim_cal_seq #(.TW(TW), .DW(DW), .MW(MW), .SETTLE_CYC(S),
    .FACT_TRIM(FACT), .MODE_RST(MRST), .CAL_MODE(CALM)) dut_i (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cmp_flag(cmp_flag),
    .usr_wr(usr_wr), .usr_code(usr_code), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .out_en_cfg(out_en_cfg), .dat_in(dat_in),
    .out_en(out_en), .dat_out(dat_out), .chan_mode(chan_mode),
    .cal_en(cal_en), .trim_code(trim_code), .trim_user(trim_user),
    .busy(busy), .done(done), .err(err));

  function automatic int code_after(int k, int t);
    int c = 16;
    int s = 8;
    for (int i = 0; i < 4 && i < k; i++) begin
      c = (c >= t) ? c - s : c + s;
      s = s / 2;
    end
    if (k >= 5 && !(c >= t)) c = (c + 1 > 31) ? 31 : c + 1;
    return c;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference
  int m_trim, m_mode, m_saved, el;
  bit m_busy, m_user, m_done, m_err;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_trim = FACT; m_user = 0; m_mode = MRST;
      m_done = 0; m_err = 0; el = 0; m_saved = 0;
    end else begin
      m_done = 0;
      m_err  = cal_start && m_busy;
      if (m_busy) begin
        el++;
        if (el % S == 0) begin
          m_trim = code_after(el / S, tgt);
          if (el / S == 5) begin
            m_busy = 0; m_done = 1; m_user = 1; m_mode = m_saved;
          end
        end
      end else if (cal_start) begin
        m_busy = 1; el = 0; m_trim = 16; m_saved = m_mode; m_mode = CALM;
      end else begin
        if (usr_wr) begin m_trim = usr_code; m_user = 1; end
        if (mode_wr) m_mode = mode_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(trim_code == m_trim, "R4", "trim_code", trim_code, m_trim);
      chk(trim_user == m_user, "R9", "trim_user", trim_user, m_user);
      chk(busy == m_busy, "R6", "busy", busy, m_busy);
      chk(cal_en == m_busy, "R6", "cal_en", cal_en, m_busy);
      chk(done == m_done, "R6", "done", done, m_done);
      chk(err == m_err, "R8", "err", err, m_err);
      chk(chan_mode == m_mode, "R7", "chan_mode", chan_mode, m_mode);
      chk(out_en == (out_en_cfg && !m_busy), "R3", "out_en", out_en, out_en_cfg && !m_busy);
      chk(dat_out == (m_busy ? 12'h800 : dat_in), "R3", "dat_out", dat_out,
          m_busy ? 12'h800 : dat_in);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_cal(int t, bit poke);
    int left;
    tgt = t;
    @(negedge clk) cal_start = 1;
    @(negedge clk) cal_start = 0;
    chk(busy == 1, "R2", "busy after start", busy, 1);
    chk(trim_code == 16, "R2", "first candidate", trim_code, 16);
    chk(chan_mode == CALM, "R2", "cal mode", chan_mode, CALM);
    chk(dat_out == 12'h800 && out_en == 0, "R3", "forced data", dat_out, 12'h800);
    left = 5 * S;
    if (poke) begin
      @(negedge clk);
      cal_start = 1; usr_wr = 1; usr_code = 3; mode_wr = 1; mode_wdata = 6;
      @(negedge clk);
      cal_start = 0; usr_wr = 0; mode_wr = 0;
      chk(err == 1, "R8", "err on busy start", err, 1);
      chk(trim_code == 16, "R9", "usr write ignored while busy", trim_code, 16);
      left = left - 2;
    end
    repeat (left) @(negedge clk);
    chk(done == 1, "R6", "done pulse", done, 1);
    chk(busy == 0, "R6", "busy cleared", busy, 0);
    chk(trim_code == code_after(5, t), "R5", "final code", trim_code, code_after(5, t));
    chk(trim_user == 1, "R6", "source user", trim_user, 1);
    @(negedge clk);
    chk(done == 0, "R6", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(trim_code == FACT, "R1", "reset trim", trim_code, FACT);
    chk(trim_user == 0, "R1", "reset source", trim_user, 0);
    chk(chan_mode == MRST, "R1", "reset mode", chan_mode, MRST);
    chk(busy == 0 && done == 0 && err == 0 && cal_en == 0, "R1", "reset flags", busy, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(trim_code == FACT, "R10", "idle hold", trim_code, FACT);

    @(negedge clk) mode_wr = 1; mode_wdata = 5;
    @(negedge clk) mode_wr = 0;
    chk(chan_mode == 5, "R7", "idle mode write", chan_mode, 5);

    run_cal(13, 0);
    chk(chan_mode == 5, "R7", "mode restored", chan_mode, 5);
    run_cal(0, 0);
    chk(trim_code == 1, "R4", "all-high search", trim_code, 1);
    run_cal(32, 1);
    chk(trim_code == 31, "R5", "saturate at top", trim_code, 31);
    chk(chan_mode == 5, "R7", "mode write dropped while busy", chan_mode, 5);
    run_cal(16, 0);
    run_cal(7, 0);
    run_cal(31, 0);
    run_cal(20, 0);

    @(negedge clk) usr_wr = 1; usr_code = 22;
    @(negedge clk) usr_wr = 0;
    chk(trim_code == 22, "R9", "idle user write", trim_code, 22);
    repeat (3) @(negedge clk);
    chk(trim_code == 22, "R10", "hold after write", trim_code, 22);

    tgt = 9;
    @(negedge clk) usr_wr = 1; usr_code = 2; cal_start = 1;
    @(negedge clk) usr_wr = 0; cal_start = 0;
    chk(trim_code == 16, "R9", "start beats user write", trim_code, 16);
    repeat (5 * S) @(negedge clk);
    chk(trim_code == code_after(5, 9), "R5", "final after race", trim_code, code_after(5, 9));
    repeat (3) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule